// File: doc/BRIEF.md
# Readout Chip Command Decoder

This block is the control logic of one readout chip in a module of up to eight chips that share a command bus and an 8-bit data bus. Each chip has a strapped 3-bit identity. A command is a 3-bit opcode sent with a 3-bit address. Only the chip whose identity equals the address acts on the command. The block turns an accepted command into one of the following:

- a gate setting;
- a one-cycle readout request, either destructive or non-destructive;
- a calibration injection pulse, long or short;
- a one-cycle test count pulse;
- a write to one of six converter setting registers.

It also drives the output enable of the chip's tristate data bus. The enable is held from a readout command until the counter array reports that the readout has finished.

The gate command and the load command take their operands as bytes that follow the command. The operand bytes arrive on the data bus and are marked by a byte strobe. While the block is waiting for operand bytes, or while a calibration pulse runs, it reports busy and drops every new command. The sender must retry such a command later. The six setting registers have different widths: two 8-bit thresholds, three 5-bit biases and one 4-bit calibration amplitude. A value that is wider than its register is cut to the register's low bits.

Top module: `rdo_cmd_ctrl`

## Requirements
- R1: An accepted opcode 001 gives `rd_clear_req` high for exactly one cycle, opcode 010 gives `rd_keep_req`, and opcode 101 gives `cnt_pulse`. The pulse is visible in the cycle after the accepting clock edge, and at most one of these three outputs is high at a time.
- R2: Opcode 111 causes no action: no request, no pulse, no busy, and no change to any setting register or to the gate.
- R3: A command is accepted only when `cmd_valid` is high, `cmd_addr` equals `chip_id` and `busy` is low. A command with any other address has no effect, and neither do the data bytes that follow it.
- R4: `bus_oe` rises in the cycle after an accepted opcode 001 or 010. It stays high until a cycle in which `rd_done` is high, and falls one cycle after that. No other command raises it.
- R5: An accepted opcode 011 raises `cal_pulse` for exactly 64 consecutive cycles (default `LONG_CYC`). Opcode 100 raises it for exactly 8 cycles (default `SHORT_CYC`).
- R6: `busy` is high while `cal_pulse` is high and while operand bytes are awaited. A command presented while `busy` is high is dropped.
- R7: Opcode 110 (load) takes two strobed bytes: an index, then a value. The index selects the register: 0 = `thr_lo`, 1 = `thr_hi`, 2 = `bias_a`, 3 = `bias_b`, 4 = `bias_c`, 5 = `cal_amp`. The value is cut to the register's low bits, and the register shows it in the cycle after the second byte.
- R8: If the index byte of a load is greater than 5, the value byte is still consumed but no register changes.
- R9: Opcode 000 takes one strobed byte. Bit 0 of that byte becomes `gate_en` in the cycle after the byte.
- R10: After a synchronous reset, the following hold: `thr_lo` = `thr_hi` = 255, the three biases = 16, `cal_amp` = 0, and `gate_en`, `bus_oe`, `busy`, `cal_pulse` and all request outputs = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_id | input | 3 | Strapped identity of this chip |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 3 | Chip address of the command |
| byte_valid | input | 1 | Operand byte present this cycle |
| byte_data | input | 8 | Operand byte |
| rd_done | input | 1 | Counter array has finished driving the bus |
| busy | output | 1 | Commands are being dropped |
| gate_en | output | 1 | Counting gate enable |
| rd_clear_req | output | 1 | Destructive readout request, one cycle |
| rd_keep_req | output | 1 | Non-destructive readout request, one cycle |
| cal_pulse | output | 1 | Calibration injection pulse |
| cnt_pulse | output | 1 | Test count pulse, one cycle |
| bus_oe | output | 1 | Output enable of the tristate data bus |
| thr_lo | output | 8 | Lower threshold setting |
| thr_hi | output | 8 | Upper threshold setting |
| bias_a | output | 5 | First bias setting |
| bias_b | output | 5 | Second bias setting |
| bias_c | output | 5 | Third bias setting |
| cal_amp | output | 4 | Calibration amplitude setting |

## Verification
The bench sends a count command in the middle of a long calibration pulse. A block that does not drop busy-time commands would emit a stray count pulse there. The bench also loads values wider than the 5-bit and 4-bit registers. A block that does not cut the value would show high bits that the register cannot hold. Two more cases target the operand path: an index of 6 must leave every register alone, and the bytes that follow a command for another chip must be ignored. A block that gets either wrong would overwrite a setting. Finally, the bench measures each calibration pulse edge to edge, and checks that `bus_oe` survives until `rd_done`. An off-by-one counter would show up as a pulse of 63 or 65 cycles.

// File: rtl/rdo_cmd_pkg.sv
package rdo_cmd_pkg;

  localparam int NUM_DAC = 6;
  localparam int BYTE_W  = 8;
  localparam int THR_W   = 8;
  localparam int BIAS_W  = 5;
  localparam int CAL_W   = 4;

  typedef enum logic [2:0] {
    OP_GATE      = 3'b000,
    OP_RD_CLEAR  = 3'b001,
    OP_RD_KEEP   = 3'b010,
    OP_CAL_LONG  = 3'b011,
    OP_CAL_SHORT = 3'b100,
    OP_COUNT     = 3'b101,
    OP_LOAD      = 3'b110,
    OP_NONE      = 3'b111
  } op_e;

  typedef struct packed {
    logic set_gate;
    logic rd_clear;
    logic rd_keep;
    logic cal_long;
    logic cal_short;
    logic count;
    logic load;
  } cmd_hit_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GATE_BYTE,
    ST_IDX_BYTE,
    ST_VAL_BYTE
  } byte_st_e;

  function automatic int dac_width(input int idx);
    case (idx)
      0, 1:    return THR_W;
      2, 3, 4: return BIAS_W;
      default: return CAL_W;
    endcase
  endfunction

  function automatic int dac_reset(input int idx);
    case (idx)
      0, 1:    return 255;
      2, 3, 4: return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rdo_cmd_decode.sv
module rdo_cmd_decode
  import rdo_cmd_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [ID_W-1:0] cmd_addr,
  input  logic [ID_W-1:0] chip_id,
  input  logic            busy,
  output cmd_hit_t        hit
);

  logic accept;

  assign accept = cmd_valid && (cmd_addr == chip_id) && !busy;

  always_comb begin
    hit = '0;
    if (accept) begin
      case (op_e'(cmd_op))
        OP_GATE:      hit.set_gate  = 1'b1;
        OP_RD_CLEAR:  hit.rd_clear  = 1'b1;
        OP_RD_KEEP:   hit.rd_keep   = 1'b1;
        OP_CAL_LONG:  hit.cal_long  = 1'b1;
        OP_CAL_SHORT: hit.cal_short = 1'b1;
        OP_COUNT:     hit.count     = 1'b1;
        OP_LOAD:      hit.load      = 1'b1;
        default:      hit           = '0;
      endcase
    end
  end

endmodule

// File: rtl/rdo_cal_pulse.sv
module rdo_cal_pulse #(
  parameter int LONG_CYC  = 64,
  parameter int SHORT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_long,
  input  logic start_short,
  output logic pulse
);

  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      remain <= '0;
    end else if (start_long) begin
      pulse  <= 1'b1;
      remain <= CNT_W'(LONG_CYC - 1);
    end else if (start_short) begin
      pulse  <= 1'b1;
      remain <= CNT_W'(SHORT_CYC - 1);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else begin
      pulse <= 1'b0;
    end
  end

endmodule

// File: rtl/rdo_dac_bank.sv
module rdo_dac_bank
  import rdo_cmd_pkg::*;
#(
  parameter int N_REG = NUM_DAC,
  parameter int DW    = BYTE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_idx,
  input  logic [DW-1:0]              wr_data,
  output logic [N_REG-1:0][DW-1:0]   q
);

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    localparam int RW = dac_width(g);
    localparam int RV = dac_reset(g);
    logic [RW-1:0] r;

    always_ff @(posedge clk) begin
      if (rst) begin
        r <= RW'(RV);
      end else if (wr_en && (int'(wr_idx) == g)) begin
        r <= wr_data[RW-1:0];
      end
    end

    assign q[g] = DW'(r);
  end

endmodule

// File: rtl/rdo_cmd_ctrl.sv
module rdo_cmd_ctrl
  import rdo_cmd_pkg::*;
#(
  parameter int ID_W      = 3,
  parameter int LONG_CYC  = 64,
  parameter int SHORT_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   chip_id,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ID_W-1:0]   cmd_addr,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              rd_done,
  output logic              busy,
  output logic              gate_en,
  output logic              rd_clear_req,
  output logic              rd_keep_req,
  output logic              cal_pulse,
  output logic              cnt_pulse,
  output logic              bus_oe,
  output logic [THR_W-1:0]  thr_lo,
  output logic [THR_W-1:0]  thr_hi,
  output logic [BIAS_W-1:0] bias_a,
  output logic [BIAS_W-1:0] bias_b,
  output logic [BIAS_W-1:0] bias_c,
  output logic [CAL_W-1:0]  cal_amp
);

  cmd_hit_t                        hit;
  byte_st_e                        state;
  logic [2:0]                      idx_q;
  logic                            idx_ok;
  logic                            dac_we;
  logic [NUM_DAC-1:0][BYTE_W-1:0]  dac_q;

  rdo_cmd_decode #(.ID_W(ID_W)) u_decode (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .chip_id   (chip_id),
    .busy      (busy),
    .hit       (hit)
  );

  rdo_cal_pulse #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_cal (
    .clk         (clk),
    .rst         (rst),
    .start_long  (hit.cal_long),
    .start_short (hit.cal_short),
    .pulse       (cal_pulse)
  );

  assign busy   = cal_pulse || (state != ST_IDLE);
  assign dac_we = (state == ST_VAL_BYTE) && byte_valid && idx_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      gate_en      <= 1'b0;
      rd_clear_req <= 1'b0;
      rd_keep_req  <= 1'b0;
      cnt_pulse    <= 1'b0;
      bus_oe       <= 1'b0;
      idx_q        <= '0;
      idx_ok       <= 1'b0;
    end else begin
      rd_clear_req <= hit.rd_clear;
      rd_keep_req  <= hit.rd_keep;
      cnt_pulse    <= hit.count;

      if (hit.rd_clear || hit.rd_keep) begin
        bus_oe <= 1'b1;
      end else if (rd_done) begin
        bus_oe <= 1'b0;
      end

      case (state)
        ST_IDLE: begin
          if (hit.set_gate) begin
            state <= ST_GATE_BYTE;
          end else if (hit.load) begin
            state <= ST_IDX_BYTE;
          end
        end
        ST_GATE_BYTE: begin
          if (byte_valid) begin
            gate_en <= byte_data[0];
            state   <= ST_IDLE;
          end
        end
        ST_IDX_BYTE: begin
          if (byte_valid) begin
            idx_q  <= byte_data[2:0];
            idx_ok <= (int'(byte_data) < NUM_DAC);
            state  <= ST_VAL_BYTE;
          end
        end
        ST_VAL_BYTE: begin
          if (byte_valid) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  rdo_dac_bank #(.N_REG(NUM_DAC), .DW(BYTE_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (dac_we),
    .wr_idx  (idx_q),
    .wr_data (byte_data),
    .q       (dac_q)
  );

  assign thr_lo  = dac_q[0][THR_W-1:0];
  assign thr_hi  = dac_q[1][THR_W-1:0];
  assign bias_a  = dac_q[2][BIAS_W-1:0];
  assign bias_b  = dac_q[3][BIAS_W-1:0];
  assign bias_c  = dac_q[4][BIAS_W-1:0];
  assign cal_amp = dac_q[5][CAL_W-1:0];

endmodule

// File: rtl/rdo_cmd_ctrl_chk.sv
module rdo_cmd_ctrl_chk #(
  parameter int ID_W      = 3,
  parameter int LONG_CYC  = 64,
  parameter int SHORT_CYC = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [ID_W-1:0] chip_id,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input logic [ID_W-1:0] cmd_addr,
  input logic            rd_done,
  input logic            busy,
  input logic            rd_clear_req,
  input logic            rd_keep_req,
  input logic            cal_pulse,
  input logic            cnt_pulse,
  input logic            bus_oe
);

  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)            run_len <= '0;
    else if (cal_pulse) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_clear_req, rd_keep_req, cnt_pulse})); // R1

  AST_SPARE_OP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'b111) |=> !rd_clear_req && !rd_keep_req && !cnt_pulse); // R2

  AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_addr != chip_id) |=> !rd_clear_req && !rd_keep_req && !cnt_pulse); // R3

  AST_BUS_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(cmd_valid && cmd_addr == chip_id &&
                            (cmd_op == 3'b001 || cmd_op == 3'b010))); // R4

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && !rd_done) |=> bus_oe); // R4

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_pulse) |-> (int'(run_len) == LONG_CYC || int'(run_len) == SHORT_CYC)); // R5

  AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (rst)
    cal_pulse |-> busy); // R6

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy) |=> !rd_clear_req && !rd_keep_req && !cnt_pulse); // R6

endmodule

bind rdo_cmd_ctrl rdo_cmd_ctrl_chk #(
  .ID_W(ID_W), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .chip_id(chip_id), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .rd_done(rd_done), .busy(busy),
  .rd_clear_req(rd_clear_req), .rd_keep_req(rd_keep_req),
  .cal_pulse(cal_pulse), .cnt_pulse(cnt_pulse), .bus_oe(bus_oe)
);

// File: tb/rdo_cmd_ctrl_bench.sv
module rdo_cmd_ctrl_bench;

  localparam logic [2:0] MY_ID = 3'd5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] chip_id = MY_ID;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [2:0] cmd_addr = '0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       rd_done = 1'b0;
  logic       busy, gate_en, rd_clear_req, rd_keep_req, cal_pulse, cnt_pulse, bus_oe;
  logic [7:0] thr_lo, thr_hi;
  logic [4:0] bias_a, bias_b, bias_c;
  logic [3:0] cal_amp;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rdo_cmd_ctrl u_rdo_cmd_ctrl (
    .clk(clk), .rst(rst), .chip_id(chip_id), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .byte_valid(byte_valid),
    .byte_data(byte_data), .rd_done(rd_done), .busy(busy), .gate_en(gate_en),
    .rd_clear_req(rd_clear_req), .rd_keep_req(rd_keep_req),
    .cal_pulse(cal_pulse), .cnt_pulse(cnt_pulse), .bus_oe(bus_oe),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .bias_a(bias_a), .bias_b(bias_b),
    .bias_c(bias_c), .cal_amp(cal_amp)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [2:0] addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 thr_lo", thr_lo, 255);
    check("R10 thr_hi", thr_hi, 255);
    check("R10 biases", {bias_a, bias_b, bias_c}, {5'd16, 5'd16, 5'd16});
    check("R10 cal_amp", cal_amp, 0);
    check("R10 flags", {gate_en, bus_oe, busy, cal_pulse, rd_clear_req, rd_keep_req, cnt_pulse}, 0);
  endtask

  task automatic t_opcodes;
    send_cmd(3'b101, MY_ID);
    check("R1 count pulse", {rd_clear_req, rd_keep_req, cnt_pulse}, 3'b001);
    @(negedge clk);
    check("R1 count one cycle", cnt_pulse, 0);
  endtask

  task automatic t_readout;
    send_cmd(3'b001, MY_ID);
    check("R1 clear req", {rd_clear_req, rd_keep_req, cnt_pulse}, 3'b100);
    check("R4 oe up", bus_oe, 1);
    repeat (3) @(negedge clk);
    check("R1 clear req one cycle", rd_clear_req, 0);
    check("R4 oe held", bus_oe, 1);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    check("R4 oe down", bus_oe, 0);
    send_cmd(3'b010, MY_ID);
    check("R1 keep req", {rd_clear_req, rd_keep_req, cnt_pulse}, 3'b010);
    check("R4 oe up keep", bus_oe, 1);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    check("R4 oe down keep", bus_oe, 0);
  endtask

  task automatic t_spare_and_foreign;
    send_cmd(3'b111, MY_ID);
    check("R2 spare quiet", {busy, cal_pulse, rd_clear_req, rd_keep_req, cnt_pulse, bus_oe}, 0);
    check("R2 spare no setting", {thr_lo, cal_amp}, {8'd255, 4'd0});
    send_cmd(3'b001, 3'd2);
    check("R3 foreign read", {rd_clear_req, bus_oe}, 0);
    send_cmd(3'b110, 3'd2);
    check("R3 foreign load busy", busy, 0);
    send_byte(8'd0);
    send_byte(8'd7);
    check("R3 foreign bytes", thr_lo, 255);
  endtask

  task automatic t_cal(input logic [2:0] op, input int exp_len, input string req);
    int n;
    n = 0;
    send_cmd(op, MY_ID);
    while (cal_pulse && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(req, n, exp_len);
  endtask

  task automatic t_busy;
    send_cmd(3'b011, MY_ID);
    repeat (10) @(negedge clk);
    check("R6 busy in pulse", busy, 1);
    send_cmd(3'b101, MY_ID);
    check("R6 dropped count", cnt_pulse, 0);
    while (cal_pulse) @(negedge clk);
    check("R6 busy clears", busy, 0);
    send_cmd(3'b000, MY_ID);
    check("R6 busy awaiting byte", busy, 1);
    send_cmd(3'b101, MY_ID);
    check("R6 dropped during wait", cnt_pulse, 0);
    send_byte(8'h00);
  endtask

  task automatic t_dac;
    send_cmd(3'b110, MY_ID); send_byte(8'd0); send_byte(8'd40);
    check("R7 thr_lo", thr_lo, 40);
    send_cmd(3'b110, MY_ID); send_byte(8'd1); send_byte(8'd200);
    check("R7 thr_hi", thr_hi, 200);
    send_cmd(3'b110, MY_ID); send_byte(8'd2); send_byte(8'hFF);
    check("R7 bias_a cut", bias_a, 31);
    send_cmd(3'b110, MY_ID); send_byte(8'd3); send_byte(8'h23);
    check("R7 bias_b cut", bias_b, 3);
    send_cmd(3'b110, MY_ID); send_byte(8'd4); send_byte(8'd9);
    check("R7 bias_c", bias_c, 9);
    send_cmd(3'b110, MY_ID); send_byte(8'd5); send_byte(8'hAB);
    check("R7 cal_amp cut", cal_amp, 11);
    send_cmd(3'b110, MY_ID); send_byte(8'd6); send_byte(8'h00);
    check("R8 bad index thr", {thr_lo, thr_hi}, {8'd40, 8'd200});
    check("R8 bad index rest", {bias_a, bias_b, bias_c, cal_amp}, {5'd31, 5'd3, 5'd9, 4'd11});
    check("R8 value consumed", busy, 0);
  endtask

  task automatic t_gate;
    send_cmd(3'b000, MY_ID); send_byte(8'h01);
    check("R9 gate on", gate_en, 1);
    send_cmd(3'b000, MY_ID); send_byte(8'hFE);
    check("R9 gate off", gate_en, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_opcodes();
    t_readout();
    t_spare_and_foreign();
    t_cal(3'b011, 64, "R5 long width");
    t_cal(3'b100, 8, "R5 short width");
    t_busy();
    t_dac();
    t_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule